// File: doc/BRIEF.md
# Ethernet Frame Statistics Counter Bank

This block keeps per-port traffic statistics for an Ethernet MAC. At the end of every received and every transmitted frame, the MAC presents a one-cycle summary on the matching side of the block. The summary carries the frame length, the destination address, a few type flags and the error status. The block sorts each frame into its categories and its size class, then advances the matching counters in the same clock edge. Octet counters advance by the frame length. All other counters advance by one.

Each counter is `CNT_W` bits wide, 64 by default, and saturates instead of wrapping. Software reads a counter as two 32-bit words through a small register port. Reading the lower word captures the upper word of the same counter into a shadow register, so a 64-bit value read across two accesses stays coherent. The same register port also holds a programmable maximum frame length. That length bounds the largest size class and sets the point where a frame counts as oversized. A synchronous clear input zeroes the whole bank.

Top module: `stat_counter_bank`

## Requirements
- R1: Word address 2i reads bits 31:0 of receive counter i, and 2i+1 reads its upper word. Transmit counter j sits at 64+2j and 65+2j. `reg_rdata` is valid the cycle after `reg_rd` and is zero in every other cycle and for unmapped addresses.
- R2: An upper-word read returns the upper word captured at the most recent lower-word read, not the live counter.
- R3: Both sides classify frames of 64 bytes, 65–127, 128–255, 256–511, 512–1023, 1024–1518, and 1519 up to the maximum length into counters rx 19–25 and tx 11–17, in that order. A frame shorter than 64 bytes or longer than the maximum falls in no size class.
- R4: Address 0xFE holds the 16-bit maximum length (reset value 1518), written through `reg_wr` and `reg_wdata[15:0]` and readable. A new value applies to frames from the next cycle.
- R5: A receive frame under 64 bytes counts in rx 13 (undersized) when its CRC is good and in rx 16 (fragment) when its CRC is bad.
- R6: A receive frame over the maximum counts in rx 14 (oversized) when its CRC is good and in rx 15 (jabber) when its CRC is bad.
- R7: A destination of all ones is broadcast. With `dest[40]` set it is otherwise multicast, and unicast in every other case. These go to rx 8/9/10 (unicast/multicast/broadcast) and tx 6/7/8.
- R8: Rx 0 adds the length of good frames. Rx 1 and tx 0 add the length of every frame.
- R9: A counter that would pass its maximum value stays at all ones.
- R10: `clr` zeroes every counter and the shadow word on the next edge and takes priority over counting. The maximum length is kept.
- R11: A transmit frame is good when neither `tx_crc_bad` nor `tx_mac_err` is set. The transmit counters are: tx 1 good pause, tx 2 good frames, tx 3 CRC errors, tx 4 good VLAN, tx 5 errored, tx 9 all frames, tx 10 under 64 bytes, tx 18 good control.
- R12: A receive frame is good when none of `rx_crc_bad`, `rx_align_err` or `rx_mac_err` is set. The receive counters are: rx 2 alignment errors, rx 3 good pause, rx 4 good frames, rx 5 CRC errors, rx 6 good VLAN, rx 7 errored, rx 11 dropped, rx 12 all frames, rx 17 good control, rx 18 dropped and not truncated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters |
| rx_valid | input | 1 | Receive summary present |
| rx_len | input | LEN_W | Receive frame length in bytes |
| rx_dest | input | 48 | Receive destination address, first octet in 47:40 |
| rx_vlan | input | 1 | Receive frame is tagged |
| rx_pause | input | 1 | Receive frame is a pause frame |
| rx_ctrl | input | 1 | Receive frame is a control frame |
| rx_crc_bad | input | 1 | Receive CRC mismatch |
| rx_align_err | input | 1 | Receive alignment error |
| rx_mac_err | input | 1 | Other receive MAC error |
| rx_drop | input | 1 | Receive frame was dropped |
| rx_trunc | input | 1 | Dropped frame was truncated |
| tx_valid | input | 1 | Transmit summary present |
| tx_len | input | LEN_W | Transmit frame length in bytes |
| tx_dest | input | 48 | Transmit destination address |
| tx_vlan | input | 1 | Transmit frame is tagged |
| tx_pause | input | 1 | Transmit frame is a pause frame |
| tx_ctrl | input | 1 | Transmit frame is a control frame |
| tx_crc_bad | input | 1 | Transmit CRC error |
| tx_mac_err | input | 1 | Other transmit MAC error |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the strobe |

## Verification
A frame summary presented in cycle N reaches its counters at the edge that closes cycle N. The bench therefore drives a summary at a falling edge, drops `rx_valid` and `tx_valid` at the next falling edge, and updates its behavioural model at that point. A read strobe driven at a falling edge returns data at the next falling edge, one register later, and the bench samples there. No frame is presented while a read is in flight, except in the deliberate shadow test, where a frame lands between the lower-word and upper-word reads. A write to the maximum length is likewise followed by one idle cycle before the next frame.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int RX_NCNT   = 26;
  localparam int TX_NCNT   = 19;
  localparam int NBKT      = 7;
  localparam int MIN_FRAME = 64;
  localparam int TX_BASE   = 64;
  localparam int LIMIT_ADR = 254;

  typedef struct packed {
    logic            good;
    logic            err;
    logic            uni;
    logic            multi;
    logic            brd;
    logic            short_ok;
    logic            short_bad;
    logic            long_ok;
    logic            long_bad;
    logic [NBKT-1:0] bkt;
  } frame_class_t;
endpackage

// File: rtl/stat_frame_classifier.sv
module stat_frame_classifier
  import stat_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] max_len,
  input  logic [47:0]      dest,
  input  logic             crc_bad,
  input  logic             other_err,
  output frame_class_t     cls
);
  logic is_short, is_long, all_ones;

  always_comb begin
    cls       = '0;
    all_ones  = &dest;
    is_short  = int'(len) < MIN_FRAME;
    is_long   = len > max_len;
    cls.good  = !crc_bad && !other_err;
    cls.err   = crc_bad || other_err;
    cls.brd   = all_ones;
    cls.multi = dest[40] && !all_ones;
    cls.uni   = !dest[40];
    cls.short_ok  = is_short && !crc_bad;
    cls.short_bad = is_short && crc_bad;
    cls.long_ok   = is_long && !crc_bad;
    cls.long_bad  = is_long && crc_bad;
    if (!is_short && !is_long) begin
      if (int'(len) == MIN_FRAME)  cls.bkt[0] = 1'b1;
      else if (int'(len) <= 127)   cls.bkt[1] = 1'b1;
      else if (int'(len) <= 255)   cls.bkt[2] = 1'b1;
      else if (int'(len) <= 511)   cls.bkt[3] = 1'b1;
      else if (int'(len) <= 1023)  cls.bkt[4] = 1'b1;
      else if (int'(len) <= 1518)  cls.bkt[5] = 1'b1;
      else                         cls.bkt[6] = 1'b1;
    end
  end

  always_comb begin
    AST_ONE_SIZE_CLASS: assert ($onehot0({cls.bkt, cls.short_ok, cls.short_bad,
                                          cls.long_ok, cls.long_bad})); // R3
    AST_ONE_DEST_CLASS: assert ($onehot({cls.uni, cls.multi, cls.brd})); // R7
  end
endmodule

// File: rtl/stat_counter.sv
module stat_counter #(
  parameter int CNT_W = 64,
  parameter int AMT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [AMT_W-1:0] amt,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W:0]   sum;
  logic [CNT_W-1:0] cnt_next;
  logic             cnt_en;

  always_comb begin
    sum      = {1'b0, cnt} + (CNT_W+1)'(amt);
    cnt_en   = clr || inc;
    cnt_next = cnt;
    if (clr)                cnt_next = '0;
    else if (sum[CNT_W])    cnt_next = '1;
    else                    cnt_next = sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_next;
  end

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (&cnt)) |=> (&cnt)); // R9
  AST_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> cnt >= $past(cnt)); // R8
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0); // R10
endmodule

// File: rtl/stat_counter_bank.sv
module stat_counter_bank
  import stat_pkg::*;
#(
  parameter int CNT_W      = 64,
  parameter int LEN_W      = 16,
  parameter int ADDR_W     = 8,
  parameter int DEF_MAXLEN = 1518
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rx_valid,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic [47:0]       rx_dest,
  input  logic              rx_vlan,
  input  logic              rx_pause,
  input  logic              rx_ctrl,
  input  logic              rx_crc_bad,
  input  logic              rx_align_err,
  input  logic              rx_mac_err,
  input  logic              rx_drop,
  input  logic              rx_trunc,
  input  logic              tx_valid,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic [47:0]       tx_dest,
  input  logic              tx_vlan,
  input  logic              tx_pause,
  input  logic              tx_ctrl,
  input  logic              tx_crc_bad,
  input  logic              tx_mac_err,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  localparam int WADDR_W = ADDR_W - 1;

  frame_class_t       rx_cls, tx_cls;
  logic [RX_NCNT-1:0] rx_inc;
  logic [TX_NCNT-1:0] tx_inc;
  logic [CNT_W-1:0]   rx_cnt [RX_NCNT];
  logic [CNT_W-1:0]   tx_cnt [TX_NCNT];
  logic [LEN_W-1:0]   max_len, max_len_next;
  logic [31:0]        shadow, shadow_next, rdata_next;
  logic [CNT_W-1:0]   sel;
  logic               hit, upper_half, limit_hit;
  logic               unused_bits;

  assign unused_bits = ^{reg_wdata[31:LEN_W], tx_cls.long_ok, tx_cls.long_bad};

  stat_frame_classifier #(.LEN_W(LEN_W)) u_rx_cls (
    .len(rx_len), .max_len(max_len), .dest(rx_dest), .crc_bad(rx_crc_bad),
    .other_err(rx_align_err || rx_mac_err), .cls(rx_cls));

  stat_frame_classifier #(.LEN_W(LEN_W)) u_tx_cls (
    .len(tx_len), .max_len(max_len), .dest(tx_dest), .crc_bad(tx_crc_bad),
    .other_err(tx_mac_err), .cls(tx_cls));

  always_comb begin
    rx_inc = {rx_cls.bkt,
              rx_drop && !rx_trunc, rx_ctrl && rx_cls.good,
              rx_cls.short_bad, rx_cls.long_bad, rx_cls.long_ok, rx_cls.short_ok,
              1'b1, rx_drop, rx_cls.brd, rx_cls.multi, rx_cls.uni,
              rx_cls.err, rx_vlan && rx_cls.good, rx_crc_bad, rx_cls.good,
              rx_pause && rx_cls.good, rx_align_err, 1'b1, rx_cls.good};
    if (!rx_valid) rx_inc = '0;
    tx_inc = {tx_ctrl && tx_cls.good, tx_cls.bkt,
              tx_cls.short_ok || tx_cls.short_bad, 1'b1,
              tx_cls.brd, tx_cls.multi, tx_cls.uni, tx_cls.err,
              tx_vlan && tx_cls.good, tx_crc_bad, tx_cls.good,
              tx_pause && tx_cls.good, 1'b1};
    if (!tx_valid) tx_inc = '0;
  end

  for (genvar i = 0; i < RX_NCNT; i++) begin : g_rx
    localparam bit OCTETS = (i == 0) || (i == 1);
    logic [LEN_W-1:0] amt;
    assign amt = OCTETS ? rx_len : LEN_W'(1);
    stat_counter #(.CNT_W(CNT_W), .AMT_W(LEN_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr), .inc(rx_inc[i]), .amt(amt), .cnt(rx_cnt[i]));
  end

  for (genvar j = 0; j < TX_NCNT; j++) begin : g_tx
    localparam bit OCTETS = (j == 0);
    logic [LEN_W-1:0] amt;
    assign amt = OCTETS ? tx_len : LEN_W'(1);
    stat_counter #(.CNT_W(CNT_W), .AMT_W(LEN_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(clr), .inc(tx_inc[j]), .amt(amt), .cnt(tx_cnt[j]));
  end

  always_comb begin
    hit        = 1'b0;
    sel        = '0;
    upper_half = reg_addr[0];
    limit_hit  = (int'(reg_addr) == LIMIT_ADR);
    for (int i = 0; i < RX_NCNT; i++)
      if (reg_addr[ADDR_W-1:1] == WADDR_W'(i)) begin
        hit = 1'b1;
        sel = rx_cnt[i];
      end
    for (int j = 0; j < TX_NCNT; j++)
      if (reg_addr[ADDR_W-1:1] == WADDR_W'(TX_BASE/2 + j)) begin
        hit = 1'b1;
        sel = tx_cnt[j];
      end

    rdata_next = '0;
    if (reg_rd) begin
      if (limit_hit)       rdata_next = 32'(max_len);
      else if (hit)        rdata_next = upper_half ? shadow : sel[31:0];
    end

    shadow_next = shadow;
    if (clr)                                 shadow_next = '0;
    else if (reg_rd && hit && !upper_half)   shadow_next = 32'(sel >> 32);

    max_len_next = max_len;
    if (reg_wr && limit_hit) max_len_next = reg_wdata[LEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      shadow    <= '0;
      max_len   <= LEN_W'(DEF_MAXLEN);
    end else begin
      reg_rdata <= rdata_next;
      shadow    <= shadow_next;
      if (reg_wr) max_len <= max_len_next;
    end
  end

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> reg_rdata == '0); // R1
  AST_LIMIT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && int'(reg_addr) == LIMIT_ADR) |=> max_len == $past(reg_wdata[LEN_W-1:0])); // R4
  AST_SHADOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> shadow == '0); // R10
endmodule

// File: tb/stat_counter_bank_bench.sv
module stat_counter_bank_bench;
  localparam int CW = 33;
  localparam longint unsigned SATV = (64'd1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic rx_valid = 0, rx_vlan = 0, rx_pause = 0, rx_ctrl = 0, rx_crc_bad = 0;
  logic rx_align_err = 0, rx_mac_err = 0, rx_drop = 0, rx_trunc = 0;
  logic [15:0] rx_len = 0, tx_len = 0;
  logic [47:0] rx_dest = 0, tx_dest = 0;
  logic tx_valid = 0, tx_vlan = 0, tx_pause = 0, tx_ctrl = 0, tx_crc_bad = 0, tx_mac_err = 0;
  logic reg_rd = 0, reg_wr = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;

  int checks = 0, failures = 0;
  longint unsigned rxm [26];
  longint unsigned txm [19];
  longint unsigned maxm = 1518;

  always #10 clk = ~clk;

  stat_counter_bank #(.CNT_W(CW)) u_stat_counter_bank (.*);

  task automatic chk(string tag, longint unsigned got, longint unsigned exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic rd(input int a, output longint unsigned v);
    @(negedge clk); reg_rd = 1; reg_addr = 8'(a);
    @(negedge clk); reg_rd = 0; v = reg_rdata;
  endtask

  task automatic wr_limit(input int v);
    @(negedge clk); reg_wr = 1; reg_addr = 8'd254; reg_wdata = 32'(v);
    @(negedge clk); reg_wr = 0; maxm = longint'(v);
  endtask

  function automatic longint unsigned sadd(longint unsigned a, longint unsigned b);
    return (a + b > SATV) ? SATV : a + b;
  endfunction

  function automatic int bucket(longint unsigned l);
    if (l < 64 || l > maxm) return -1;
    if (l == 64) return 0;
    if (l <= 127) return 1;
    if (l <= 255) return 2;
    if (l <= 511) return 3;
    if (l <= 1023) return 4;
    if (l <= 1518) return 5;
    return 6;
  endfunction

  function automatic int dclass(logic [47:0] d);
    if (&d) return 2;
    if (d[40]) return 1;
    return 0;
  endfunction

  // flags: {trunc,drop,mac,align,crc,ctrl,pause,vlan}
  function automatic void rx_model(int l, logic [47:0] d, logic [7:0] f);
    bit good = !f[3] && !f[4] && !f[5];
    int b = bucket(l);
    if (good) rxm[0] = sadd(rxm[0], l);
    rxm[1] = sadd(rxm[1], l);
    if (f[4]) rxm[2] = sadd(rxm[2], 1);
    if (f[1] && good) rxm[3] = sadd(rxm[3], 1);
    if (good) rxm[4] = sadd(rxm[4], 1);
    if (f[3]) rxm[5] = sadd(rxm[5], 1);
    if (f[0] && good) rxm[6] = sadd(rxm[6], 1);
    if (!good) rxm[7] = sadd(rxm[7], 1);
    rxm[8 + dclass(d)] = sadd(rxm[8 + dclass(d)], 1);
    if (f[6]) rxm[11] = sadd(rxm[11], 1);
    rxm[12] = sadd(rxm[12], 1);
    if (l < 64) begin
      if (f[3]) rxm[16] = sadd(rxm[16], 1); else rxm[13] = sadd(rxm[13], 1);
    end
    if (l > maxm) begin
      if (f[3]) rxm[15] = sadd(rxm[15], 1); else rxm[14] = sadd(rxm[14], 1);
    end
    if (f[2] && good) rxm[17] = sadd(rxm[17], 1);
    if (f[6] && !f[7]) rxm[18] = sadd(rxm[18], 1);
    if (b >= 0) rxm[19 + b] = sadd(rxm[19 + b], 1);
  endfunction

  // flags: {mac,crc,ctrl,pause,vlan}
  function automatic void tx_model(int l, logic [47:0] d, logic [4:0] f);
    bit good = !f[3] && !f[4];
    int b = bucket(l);
    txm[0] = sadd(txm[0], l);
    if (f[1] && good) txm[1] = sadd(txm[1], 1);
    if (good) txm[2] = sadd(txm[2], 1);
    if (f[3]) txm[3] = sadd(txm[3], 1);
    if (f[0] && good) txm[4] = sadd(txm[4], 1);
    if (!good) txm[5] = sadd(txm[5], 1);
    txm[6 + dclass(d)] = sadd(txm[6 + dclass(d)], 1);
    txm[9] = sadd(txm[9], 1);
    if (l < 64) txm[10] = sadd(txm[10], 1);
    if (b >= 0) txm[11 + b] = sadd(txm[11 + b], 1);
    if (f[2] && good) txm[18] = sadd(txm[18], 1);
  endfunction

  task automatic drive_rx(int l, logic [47:0] d, logic [7:0] f);
    rx_valid = 1; rx_len = 16'(l); rx_dest = d;
    {rx_trunc, rx_drop, rx_mac_err, rx_align_err, rx_crc_bad, rx_ctrl, rx_pause, rx_vlan} = f;
  endtask

  task automatic drive_tx(int l, logic [47:0] d, logic [4:0] f);
    tx_valid = 1; tx_len = 16'(l); tx_dest = d;
    {tx_mac_err, tx_crc_bad, tx_ctrl, tx_pause, tx_vlan} = f;
  endtask

  task automatic rx_frame(int l, logic [47:0] d, logic [7:0] f);
    @(negedge clk); drive_rx(l, d, f);
    @(negedge clk); rx_valid = 0; rx_model(l, d, f);
  endtask

  task automatic tx_frame(int l, logic [47:0] d, logic [4:0] f);
    @(negedge clk); drive_tx(l, d, f);
    @(negedge clk); tx_valid = 0; tx_model(l, d, f);
  endtask

  function automatic string rx_req(int i);
    if (i <= 1) return "R8";
    if (i >= 8 && i <= 10) return "R7";
    if (i == 13 || i == 16) return "R5";
    if (i == 14 || i == 15) return "R6";
    if (i >= 19) return "R3";
    return "R12";
  endfunction

  function automatic string tx_req(int j);
    if (j == 0) return "R8";
    if (j >= 6 && j <= 8) return "R7";
    if (j >= 11 && j <= 17) return "R3";
    return "R11";
  endfunction

  task automatic check_all(string phase);
    longint unsigned lo, hi;
    for (int i = 0; i < 26; i++) begin
      rd(2 * i, lo); rd(2 * i + 1, hi);
      chk($sformatf("%s R1 %s rx%0d", phase, rx_req(i), i), (hi << 32) | lo, rxm[i]);
    end
    for (int j = 0; j < 19; j++) begin
      rd(64 + 2 * j, lo); rd(65 + 2 * j, hi);
      chk($sformatf("%s R1 %s tx%0d", phase, tx_req(j), j), (hi << 32) | lo, txm[j]);
    end
  endtask

  function automatic logic [47:0] pick_dest(int k);
    case (k % 3)
      0: return 48'hFFFF_FFFF_FFFF;
      1: return 48'h0100_5E00_0012;
      default: return 48'h0012_3456_789A;
    endcase
  endfunction

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    longint unsigned v, v2;
    int lens[16] = '{64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 1518, 1519, 2000, 40, 63, 1600};
    foreach (rxm[i]) rxm[i] = 0;
    foreach (txm[j]) txm[j] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle rdata after reset", reg_rdata, 0);
    rd(254, v); chk("R4 max length reset value", v, 1518);
    rd(2, v);   chk("R1 reset counter rx1", v, 0);
    rd(200, v); chk("R1 unmapped address", v, 0);

    // default limit 1518: 1519 is oversized, bucket 6 unreachable
    rx_frame(1519, pick_dest(2), 8'h00);
    tx_frame(1519, pick_dest(2), 5'h00);
    check_all("limit1518");

    wr_limit(2000);
    rd(254, v); chk("R4 max length readback", v, 2000);
    for (int k = 0; k < 16; k++) begin
      rx_frame(lens[k], pick_dest(k), 8'((k * 37) ^ (k << 3)));
      tx_frame(lens[k], pick_dest(k + 1), 5'((k * 11) ^ k));
    end
    rx_frame(2001, pick_dest(0), 8'h00);  // R6 oversized good
    rx_frame(2001, pick_dest(1), 8'h08);  // R6 jabber
    rx_frame(40,   pick_dest(2), 8'h00);  // R5 undersized good
    rx_frame(40,   pick_dest(2), 8'h08);  // R5 fragment
    rx_frame(300,  pick_dest(2), 8'h40);  // R12 dropped, not truncated
    rx_frame(300,  pick_dest(2), 8'hC0);  // R12 dropped and truncated
    tx_frame(30,   pick_dest(0), 5'h00);  // R11 undersized
    check_all("mixed");

    wr_limit(1500);
    rx_frame(1510, pick_dest(1), 8'h00);  // R4 now oversized
    tx_frame(1510, pick_dest(1), 5'h00);
    check_all("limit1500");

    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    foreach (rxm[i]) rxm[i] = 0;
    foreach (txm[j]) txm[j] = 0;
    rd(254, v); chk("R10 limit kept after clear", v, 1500);
    check_all("cleared R10");

    // saturation run on the octet counters; shadow test at 2^32
    @(negedge clk);
    for (int n = 0; n < 131080; n++) begin
      drive_rx(65535, pick_dest(2), 8'h00);
      drive_tx(65535, pick_dest(2), 5'h00);
      @(negedge clk);
      rx_model(65535, pick_dest(2), 8'h00);
      tx_model(65535, pick_dest(2), 5'h00);
      if (n == 65536) begin
        rx_valid = 0; tx_valid = 0;
        rd(2, v); chk("R1 lower word before carry", v, 32'hFFFF_FFFF);
        @(negedge clk); drive_rx(65535, pick_dest(2), 8'h00);
        @(negedge clk); rx_valid = 0; rx_model(65535, pick_dest(2), 8'h00);
        rd(3, v); chk("R2 upper word from shadow", v, 0);
        rd(2, v); rd(3, v2);
        chk("R2 coherent pair after carry", (v2 << 32) | v, rxm[1]);
      end
    end
    rx_valid = 0; tx_valid = 0;
    rd(2, v); rd(3, v2); chk("R9 rx all-octet saturated", (v2 << 32) | v, SATV);
    rd(0, v); rd(1, v2); chk("R9 rx good-octet saturated", (v2 << 32) | v, SATV);
    rd(64, v); rd(65, v2); chk("R9 tx octet saturated", (v2 << 32) | v, SATV);
    rd(28, v); rd(29, v2); chk("R6 oversized count in run", (v2 << 32) | v, rxm[14]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule